// File: doc/BRIEF.md
# Standby Domain Power Sequencer

This block decides, cycle by cycle, what power state each digital domain of a chip should be in. It handles an always-on backup domain, a top domain and a stack of switchable domains numbered from 0 upward (three by default). The decision depends on the requested sleep mode. During standby it also depends on activity requests raised by peripherals or DMA triggers. A switchable domain can be active, in retention (its state held at a low supply) or off (its state lost). During standby the sequencer moves domains between retention and active without waking the CPU. It follows a strict ordering: domain n is never active unless every lower-numbered domain is active.

Each switchable domain is run by its own state machine with four states. In S_OFF and S_RET the domain is unpowered or retained. In S_WAKE it is powering up for a fixed number of cycles. In S_ACT it is usable. The transitions are named as follows. Wake-up is S_OFF or S_RET to S_WAKE. Wake-done is S_WAKE to S_ACT, and it pulses an acknowledge. Abort is S_WAKE to S_RET or S_OFF. Drop is S_ACT to S_RET. Kill is S_ACT or S_RET to S_OFF. An always-on state machine with states W_SLEEP and W_PEND latches an interrupt seen during standby as a CPU wake request (latch: W_SLEEP to W_PEND; release: W_PEND to W_SLEEP). The same machine registers the backup and top domain state codes.

Configuration inputs let software pin domains active for the whole of standby. They also set which domains may be woken on demand, and they can link domains so that a wake of one also powers the next.

Top module: `pwrdom_seq`

## Requirements
- R1: After reset every domain reports active (code 2'b10), the wake flag is low and no acknowledge is raised.
- R2: State codes are 2'b00 off, 2'b01 retention, 2'b10 active. Mode codes are 2 idle, 4 standby, 5 backup and 6 off; any other code is run. In run and idle, every switchable domain ends up active.
- R3: The backup domain reports active in every mode except off (6), where it reports off. The top domain reports off in backup (5) and off (6) and active otherwise. Each code updates one cycle after the mode changes.
- R4: In standby, a switchable domain with no reason to stay active settles in retention. On return to run or idle, every domain comes back to active.
- R5: A domain that starts powering up spends exactly WAKE_CYC cycles reporting retention. It then reports active, and its bit of the acknowledge output is high for exactly that first active cycle.
- R6: A domain starts powering up only once the domain below it reports active. A domain leaves active only when the domain above is neither active nor powering up. Domain n active therefore always implies domain n-1 active.
- R7: In standby, a request on domain n (n = 0 or 1) wakes it only if its dynamic enable bit n is set. A request on domain 2 alone has no effect. When the honoured request falls, the domain returns to retention.
- R8: Force bit n held high keeps domain n, and by R6 every lower domain, active throughout standby.
- R9: Link field 2'b01 makes domain 1 follow domain 0. 2'b10 makes domain 2 follow domain 1. 2'b11 makes domains 1 and 2 both follow domain 0. 2'b00 links nothing.
- R10: An interrupt during standby raises the wake flag one cycle later. The flag holds until the mode leaves standby, and while it is set every switchable domain is driven active.
- R11: In backup and off modes every switchable domain goes off. A domain that is off stays off when it is later asked only for retention, and it can still be woken from off by an honoured request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_mode_i | input | 3 | Requested sleep mode code |
| dom_req_i | input | NUM_PD (3) | Per-domain activity request |
| dyn_en_i | input | NUM_DYN (2) | Per-domain dynamic wake enable, lowest domains |
| force_act_i | input | NUM_PD (3) | Keep domain active in standby |
| link_cfg_i | input | 2 | Domain linking selection |
| irq_i | input | 1 | Interrupt raised by a standby task |
| bkup_code_o | output | 2 | Backup domain state code |
| top_code_o | output | 2 | Top domain state code |
| dom_code_o | output | 2*NUM_PD (6) | Switchable domain state codes, domain n at bits [2n+1:2n] |
| dom_ack_o | output | NUM_PD (3) | One-cycle wake-done acknowledge per domain |
| cpu_wake_o | output | 1 | CPU wake request |

## Verification
The hardest situation to reach is a chain wake that is still in progress. A lower domain has finished powering up while the domain above is still reporting retention, waiting its turn. The stimulus reaches it by starting from a fully retained standby and raising a single honoured request on domain 1. It then samples at a fixed cycle count that falls between the two wake completions. The drop cascade that runs when standby is entered, and the wake-from-off path after a backup period, are reached by running the modes through run, standby, backup and back in sequence.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_RET  = 2'd1,
        S_WAKE = 2'd2,
        S_ACT  = 2'd3
    } dom_fsm_e;

    typedef enum logic {
        W_SLEEP = 1'b0,
        W_PEND  = 1'b1
    } wake_fsm_e;

    localparam logic [1:0] CODE_OFF = 2'b00;
    localparam logic [1:0] CODE_RET = 2'b01;
    localparam logic [1:0] CODE_ACT = 2'b10;

    localparam logic [2:0] MODE_IDLE = 3'd2;
    localparam logic [2:0] MODE_STBY = 3'd4;
    localparam logic [2:0] MODE_BKUP = 3'd5;
    localparam logic [2:0] MODE_OFF  = 3'd6;

    localparam logic [1:0] LINK_NONE  = 2'b00;
    localparam logic [1:0] LINK_0TO1  = 2'b01;
    localparam logic [1:0] LINK_1TO2  = 2'b10;
    localparam logic [1:0] LINK_0TO12 = 2'b11;

endpackage

// File: rtl/pds_target.sv
module pds_target
    import pds_pkg::*;
#(
    parameter int NUM_PD  = 3,
    parameter int NUM_DYN = 2
) (
    input  logic [2:0]        mode_i,
    input  logic [NUM_PD-1:0] req_i,
    input  logic [NUM_DYN-1:0] dyn_en_i,
    input  logic [NUM_PD-1:0] force_i,
    input  logic [1:0]        link_i,
    input  logic              wake_pend_i,
    output logic [NUM_PD-1:0] want_act_o,
    output logic              power_off_o
);

    logic [NUM_PD-1:0] honoured;
    logic [NUM_PD-1:0] raw_need;
    logic [NUM_PD-1:0] linked;
    logic [NUM_PD-1:0] closed;

    // Only the lowest domains carry a dynamic wake enable.
    for (genvar g = 0; g < NUM_PD; g++) begin : g_hon
        if (g < NUM_DYN) begin : g_dyn
            assign honoured[g] = req_i[g] & dyn_en_i[g];
        end else begin : g_nodyn
            assign honoured[g] = 1'b0;
        end
    end

    assign raw_need = force_i | honoured;

    always_comb begin
        linked = raw_need;
        unique case (link_i)
            LINK_0TO1:  linked[1] = raw_need[1] | raw_need[0];
            LINK_1TO2:  linked[2] = raw_need[2] | raw_need[1];
            LINK_0TO12: begin
                linked[1] = raw_need[1] | raw_need[0];
                linked[2] = raw_need[2] | raw_need[0];
            end
            default:    linked = raw_need;
        endcase
    end

    // Ordering closure: a higher domain needs every lower one.
    always_comb begin
        closed[NUM_PD-1] = linked[NUM_PD-1];
        for (int n = NUM_PD - 2; n >= 0; n--) begin
            closed[n] = linked[n] | closed[n+1];
        end
    end

    always_comb begin
        power_off_o = (mode_i == MODE_BKUP) || (mode_i == MODE_OFF);
        if (mode_i == MODE_STBY && !wake_pend_i) begin
            want_act_o = closed;
        end else begin
            want_act_o = '1;
        end
    end

endmodule

// File: rtl/pds_dom_fsm.sv
module pds_dom_fsm
    import pds_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_act_i,
    input  logic       power_off_i,
    input  logic       lower_act_i,
    input  logic       upper_busy_i,
    output logic [1:0] code_o,
    output logic       is_act_o,
    output logic       busy_o,
    output logic       ack_o
);

    localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC - 1);

    dom_fsm_e       st, nxt;
    logic [CW-1:0]  cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            S_OFF: begin
                if (!power_off_i && want_act_i && lower_act_i) nxt = S_WAKE;
            end
            S_RET: begin
                if (power_off_i)                       nxt = S_OFF;
                else if (want_act_i && lower_act_i)    nxt = S_WAKE;
            end
            S_WAKE: begin
                if (power_off_i)                       nxt = S_OFF;
                else if (!want_act_i)                  nxt = S_RET;
                else if (cnt == '0)                    nxt = S_ACT;
            end
            S_ACT: begin
                if (!upper_busy_i) begin
                    if (power_off_i)                   nxt = S_OFF;
                    else if (!want_act_i)              nxt = S_RET;
                end
            end
            default: nxt = S_OFF;
        endcase
    end

    // State register, wake counter and acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_ACT;
            cnt   <= '0;
            ack_o <= 1'b0;
        end else begin
            st    <= nxt;
            ack_o <= (st == S_WAKE) && (nxt == S_ACT);
            if (st != S_WAKE && nxt == S_WAKE) begin
                cnt <= LOAD;
            end else if (st == S_WAKE && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        unique case (st)
            S_OFF:   code_o = CODE_OFF;
            S_RET:   code_o = CODE_RET;
            S_WAKE:  code_o = CODE_RET;
            S_ACT:   code_o = CODE_ACT;
            default: code_o = CODE_OFF;
        endcase
        is_act_o = (st == S_ACT);
        busy_o   = (st == S_ACT) || (st == S_WAKE);
    end

    // R5: acknowledge lasts a single cycle
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R5: acknowledge coincides with the domain reporting active
    p_ack_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> code_o == CODE_ACT);

endmodule

// File: rtl/pds_aon.sv
module pds_aon
    import pds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       irq_i,
    output logic [1:0] bkup_code_o,
    output logic [1:0] top_code_o,
    output logic       wake_pend_o
);

    wake_fsm_e ws, ws_nxt;

    always_comb begin
        ws_nxt = ws;
        unique case (ws)
            W_SLEEP: if (mode_i == MODE_STBY && irq_i) ws_nxt = W_PEND;
            W_PEND:  if (mode_i != MODE_STBY)          ws_nxt = W_SLEEP;
            default: ws_nxt = W_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws <= W_SLEEP;
        else        ws <= ws_nxt;
    end

    // Output register for the always-on and top domain codes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bkup_code_o <= CODE_ACT;
            top_code_o  <= CODE_ACT;
        end else begin
            bkup_code_o <= (mode_i == MODE_OFF) ? CODE_OFF : CODE_ACT;
            top_code_o  <= (mode_i == MODE_OFF || mode_i == MODE_BKUP) ? CODE_OFF : CODE_ACT;
        end
    end

    assign wake_pend_o = (ws == W_PEND);

    // R3: top domain powered down one cycle after a deep mode request
    p_top_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_BKUP || mode_i == MODE_OFF) |=> top_code_o == CODE_OFF);

    // R3: backup domain stays up outside the off mode
    p_bk_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_OFF) |=> bkup_code_o == CODE_ACT);

    // R10: wake request holds while standby persists
    p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pend_o && mode_i == MODE_STBY) |=> wake_pend_o);

endmodule

// File: rtl/pwrdom_seq.sv
module pwrdom_seq
    import pds_pkg::*;
#(
    parameter int NUM_PD   = 3,
    parameter int NUM_DYN  = 2,
    parameter int WAKE_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            sleep_mode_i,
    input  logic [NUM_PD-1:0]     dom_req_i,
    input  logic [NUM_DYN-1:0]    dyn_en_i,
    input  logic [NUM_PD-1:0]     force_act_i,
    input  logic [1:0]            link_cfg_i,
    input  logic                  irq_i,
    output logic [1:0]            bkup_code_o,
    output logic [1:0]            top_code_o,
    output logic [2*NUM_PD-1:0]   dom_code_o,
    output logic [NUM_PD-1:0]     dom_ack_o,
    output logic                  cpu_wake_o
);

    logic [NUM_PD-1:0] want_act;
    logic              power_off;
    logic [NUM_PD-1:0] is_act;
    logic [NUM_PD-1:0] busy;
    logic              wake_pend;

    pds_aon u_aon (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (sleep_mode_i),
        .irq_i       (irq_i),
        .bkup_code_o (bkup_code_o),
        .top_code_o  (top_code_o),
        .wake_pend_o (wake_pend)
    );

    pds_target #(.NUM_PD(NUM_PD), .NUM_DYN(NUM_DYN)) u_target (
        .mode_i      (sleep_mode_i),
        .req_i       (dom_req_i),
        .dyn_en_i    (dyn_en_i),
        .force_i     (force_act_i),
        .link_i      (link_cfg_i),
        .wake_pend_i (wake_pend),
        .want_act_o  (want_act),
        .power_off_o (power_off)
    );

    for (genvar g = 0; g < NUM_PD; g++) begin : g_dom
        logic lower_ok;
        logic upper_bz;
        if (g == 0) begin : g_bot
            assign lower_ok = 1'b1;
        end else begin : g_mid
            assign lower_ok = is_act[g-1];
        end
        if (g == NUM_PD - 1) begin : g_top
            assign upper_bz = 1'b0;
        end else begin : g_low
            assign upper_bz = busy[g+1];
        end

        pds_dom_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .want_act_i   (want_act[g]),
            .power_off_i  (power_off),
            .lower_act_i  (lower_ok),
            .upper_busy_i (upper_bz),
            .code_o       (dom_code_o[2*g +: 2]),
            .is_act_o     (is_act[g]),
            .busy_o       (busy[g]),
            .ack_o        (dom_ack_o[g])
        );

        if (g > 0) begin : g_chk
            // R6: an active domain always has its lower neighbour active
            p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
                dom_code_o[2*g +: 2] == CODE_ACT |-> dom_code_o[2*(g-1) +: 2] == CODE_ACT);
        end

        // R11: once off in a deep mode, a domain stays off
        p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (dom_code_o[2*g +: 2] == CODE_OFF &&
             (sleep_mode_i == MODE_BKUP || sleep_mode_i == MODE_OFF))
            |=> dom_code_o[2*g +: 2] == CODE_OFF);
    end

    assign cpu_wake_o = wake_pend;

endmodule

// File: tb/tb_pwrdom_seq.sv
`timescale 1ns/1ps
module tb_pwrdom_seq;

    localparam real CLK_NS = 4.0;

    typedef struct {
        logic [5:0] dom;
        logic [1:0] bk;
        logic [1:0] top;
        logic       wake;
        logic [2:0] ack;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [2:0] req = '0;
    logic [1:0] dyn = '0;
    logic [2:0] frc = '0;
    logic [1:0] lnk = '0;
    logic       irq = 1'b0;
    logic [1:0] bk_code, top_code;
    logic [5:0] dom_code;
    logic [2:0] ack;
    logic       wake;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    exp_t exp_q[$];

    always #(CLK_NS / 2.0) clk = ~clk;

    pwrdom_seq #(.NUM_PD(3), .NUM_DYN(2), .WAKE_CYC(4)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_mode_i (mode),
        .dom_req_i    (req),
        .dyn_en_i     (dyn),
        .force_act_i  (frc),
        .link_cfg_i   (lnk),
        .irq_i        (irq),
        .bkup_code_o  (bk_code),
        .top_code_o   (top_code),
        .dom_code_o   (dom_code),
        .dom_ack_o    (ack),
        .cpu_wake_o   (wake)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_now(input logic [5:0] d, input logic [1:0] b, input logic [1:0] t,
                              input logic w, input logic [2:0] a, input string tag);
        exp_t it;
        it.dom = d; it.bk = b; it.top = t; it.wake = w; it.ack = a; it.tag = tag;
        exp_q.push_back(it);
        #0.1;
    endtask

    task automatic quiet();
        req = '0; dyn = '0; frc = '0; lnk = '0; irq = 1'b0;
    endtask

    // Monitor: pops expected items and compares against the outputs.
    initial begin
        exp_t it;
        forever begin
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            checks++;
            if (dom_code !== it.dom || bk_code !== it.bk || top_code !== it.top ||
                wake !== it.wake || ack !== it.ack) begin
                errors++;
                $display("FAIL %s: dom=%b bk=%b top=%b wake=%b ack=%b expected dom=%b bk=%b top=%b wake=%b ack=%b",
                         it.tag, dom_code, bk_code, top_code, wake, ack,
                         it.dom, it.bk, it.top, it.wake, it.ack);
            end
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R1 reset state");
        rst_n = 1'b1;
        step(2);

        mode = 3'd2; step(20);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R2 idle keeps all active");

        mode = 3'd4; step(20);
        expect_now(6'b010101, 2'b10, 2'b10, 0, 3'b000, "R4 standby drops to retention");

        // R5 exact wake timing on domain 0
        dyn = 2'b01; req = 3'b001;
        step(4);
        expect_now(6'b010101, 2'b10, 2'b10, 0, 3'b000, "R5 still waking after 4 edges");
        step(1);
        expect_now(6'b010110, 2'b10, 2'b10, 0, 3'b001, "R5 active with ack");
        step(1);
        expect_now(6'b010110, 2'b10, 2'b10, 0, 3'b000, "R5 ack single cycle");

        req = 3'b000; step(20);
        expect_now(6'b010101, 2'b10, 2'b10, 0, 3'b000, "R7 request fall returns to retention");

        dyn = 2'b11; req = 3'b100; step(20);
        expect_now(6'b010101, 2'b10, 2'b10, 0, 3'b000, "R7 domain 2 request ignored");

        dyn = 2'b01; req = 3'b010; step(20);
        expect_now(6'b010101, 2'b10, 2'b10, 0, 3'b000, "R7 domain 1 request without enable");

        quiet(); step(10);
        dyn = 2'b10; req = 3'b010;
        step(7);
        expect_now(6'b010110, 2'b10, 2'b10, 0, 3'b000, "R6 upper waits for lower");
        step(20);
        expect_now(6'b011010, 2'b10, 2'b10, 0, 3'b000, "R6 chain wake complete");

        quiet(); frc = 3'b100; step(30);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R8 forced top switchable domain");

        quiet(); step(20);
        lnk = 2'b01; dyn = 2'b01; req = 3'b001; step(30);
        expect_now(6'b011010, 2'b10, 2'b10, 0, 3'b000, "R9 link 01");

        quiet(); step(20);
        lnk = 2'b10; dyn = 2'b10; req = 3'b010; step(30);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R9 link 10");

        quiet(); step(20);
        lnk = 2'b11; dyn = 2'b01; req = 3'b001; step(30);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R9 link 11");

        quiet(); step(20);
        lnk = 2'b00; dyn = 2'b01; req = 3'b001; step(30);
        expect_now(6'b010110, 2'b10, 2'b10, 0, 3'b000, "R9 link 00");

        quiet(); step(20);
        irq = 1'b1; step(1); irq = 1'b0;
        expect_now(6'b010101, 2'b10, 2'b10, 1, 3'b000, "R10 wake raised next cycle");
        step(30);
        expect_now(6'b101010, 2'b10, 2'b10, 1, 3'b000, "R10 wake drives all active");

        mode = 3'd2; step(20);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R4 R10 leave standby");

        mode = 3'd5; step(10);
        expect_now(6'b000000, 2'b10, 2'b00, 0, 3'b000, "R3 R11 backup mode");

        mode = 3'd4; step(10);
        expect_now(6'b000000, 2'b10, 2'b10, 0, 3'b000, "R11 off stays off in standby");

        dyn = 2'b01; req = 3'b001; step(20);
        expect_now(6'b000010, 2'b10, 2'b10, 0, 3'b000, "R11 wake from off");

        quiet(); mode = 3'd6; step(10);
        expect_now(6'b000000, 2'b00, 2'b00, 0, 3'b000, "R3 off mode");

        mode = 3'd0; step(30);
        expect_now(6'b101010, 2'b10, 2'b10, 0, 3'b000, "R2 run restores all");

        #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule